// File: doc/BRIEF.md
# UART Interrupt Enable and Identification

This block keeps the interrupt-enable word of a 16550-style serial port and builds the read-only interrupt identification word that a register bus reads. It takes the interrupt conditions from the rest of the port: receive-line status, receive data available and character timeout as levels, and transmit-holding-empty, CTS transition, auto-baud timeout and end-of-auto-baud as single-cycle pulses. Each condition is gated by its enable bit. The highest-priority enabled condition is encoded into a three-bit identity with an active-low pending flag. A single interrupt request line is driven.

The identification word is held in a register. While the bus holds the identification read strobe, the word is frozen. Events that arrive during that window are kept in sticky sources and show up once the strobe drops. Reading the word while it reports transmit-holding-empty clears that source. A separate modem-status read strobe clears the CTS source. The two auto-baud conditions are sticky flags that software clears by writing ones through a clear strobe.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the enable word reads 0, the identification word reads 0x001, and `irq` is 0.
- R2: A write to the enable word stores only bits 0..3, 7, 8 and 9. All other bits read 0, so writing all ones reads back 0x38F.
- R3: Identity bits [3:1] report the highest-priority enabled source. The order, from highest, is line status 011, receive data 010, character timeout 110, transmit-holding-empty 001, modem status 000.
- R4: Bit 0 is 0 when any enabled prioritised source is pending. When none is pending, bit 0 is 1 and bits [3:1] are 000.
- R5: With `auto_cts` low, a CTS transition reports modem status when enable bit 3 is set. With `auto_cts` high, it also needs enable bit 7.
- R6: The identification word does not change while `iir_rd` is held high.
- R7: An event that arrives while `iir_rd` is high is not lost. It appears in the word after `iir_rd` falls.
- R8: The first cycle of a read that sees identity 001 clears the transmit-holding-empty source. A `msr_rd` pulse clears the modem-status source.
- R9: Bit 8 latches an auto-baud timeout and bit 9 latches end of auto-baud, whatever the enables. A pulse on `ab_clr` clears bit 8 where `ab_clr_mask[0]` is 1 and bit 9 where `ab_clr_mask[1]` is 1. A new event wins over a clear in the same cycle.
- R10: `irq` is high when an enabled prioritised source is pending, or when bit 8 is set with enable bit 8, or bit 9 is set with enable bit 9.
- R11: A source whose enable bit is 0 changes neither the identity nor `irq`. Enable bit 0 gates both receive data and character timeout, bit 1 gates transmit-holding-empty, and bit 2 gates line status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier_wr | input | 1 | Enable word write strobe |
| ier_wdata | input | DATA_W | Enable word write data |
| ier_q | output | DATA_W | Enable word read value |
| lsr_lvl | input | 1 | Receive-line status condition (level) |
| rda_lvl | input | 1 | Receive data available (level) |
| cto_lvl | input | 1 | Character timeout (level) |
| thre_evt | input | 1 | Transmit holding register became empty (pulse) |
| cts_edge | input | 1 | CTS transition seen (pulse) |
| auto_cts | input | 1 | Auto-CTS flow-control mode |
| msr_rd | input | 1 | Modem status read strobe |
| abto_evt | input | 1 | Auto-baud timeout (pulse) |
| abeo_evt | input | 1 | End of auto-baud (pulse) |
| ab_clr | input | 1 | Auto-baud flag clear strobe |
| ab_clr_mask | input | 2 | Write-one-to-clear mask for bits 8 and 9 |
| iir_rd | input | 1 | Identification read strobe, held for the read |
| iir | output | DATA_W | Identification word |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the event inputs are single-cycle pulses and that `iir_rd` is a clean strobe whose first cycle marks the start of a read. They also assume that the identification word's freeze is observed only through `iir`. The bench drives every input on the falling clock edge and gives each event a pulse exactly one cycle long. It leaves `iir_rd` high for a whole number of cycles, so that read starts are well defined. It waits two cycles after each change before it samples the registered word.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  // Enable-word bit positions (fixed by the bus map)
  localparam int B_RDA  = 0;
  localparam int B_THRE = 1;
  localparam int B_LS   = 2;
  localparam int B_MS   = 3;
  localparam int B_CTS  = 7;
  localparam int B_ABTO = 8;
  localparam int B_ABEO = 9;

  localparam int IIR_W  = 10;
  localparam int AB_N   = 2;

  typedef enum logic [2:0] {
    ID_MS   = 3'b000,
    ID_THRE = 3'b001,
    ID_RDA  = 3'b010,
    ID_LS   = 3'b011,
    ID_CTO  = 3'b110
  } irq_id_e;

  typedef struct packed {
    logic ls;
    logic rda;
    logic cto;
    logic thre;
    logic ms;
  } src_t;

  function automatic bit ier_bit_impl(int i);
    return (i <= B_MS) || (i == B_CTS) || (i == B_ABTO) || (i == B_ABEO);
  endfunction

  function automatic logic ms_gate(logic en_ms, logic en_cts, logic auto_mode);
    return en_ms & (~auto_mode | en_cts);
  endfunction

  // Returns {identity, no_pending}
  function automatic logic [3:0] encode_low(src_t s);
    logic [2:0] id;
    logic       none;
    none = 1'b0;
    if (s.ls)        id = ID_LS;
    else if (s.rda)  id = ID_RDA;
    else if (s.cto)  id = ID_CTO;
    else if (s.thre) id = ID_THRE;
    else if (s.ms)   id = ID_MS;
    else begin
      id   = 3'b000;
      none = 1'b1;
    end
    return {id, none};
  endfunction

endpackage

// File: rtl/uart_ier_reg.sv
module uart_ier_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  import uart_irq_pkg::*;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (ier_bit_impl(i)) begin : g_store
      logic b_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  b_q <= 1'b0;
        else if (wr) b_q <= wdata[i];
      end
      assign q[i] = b_q;
    end else begin : g_rsvd
      assign q[i] = 1'b0;
    end
  end

endmodule

// File: rtl/uart_irq_sources.sv
module uart_irq_sources #(
  parameter int AB_N = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            thre_evt,
  input  logic            thre_clr,
  input  logic            cts_edge,
  input  logic            msr_rd,
  input  logic [AB_N-1:0] ab_evt,
  input  logic            ab_clr,
  input  logic [AB_N-1:0] ab_clr_mask,
  output logic            thre_pend,
  output logic            ms_pend,
  output logic [AB_N-1:0] ab_flags
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thre_pend <= 1'b0;
      ms_pend   <= 1'b0;
    end else begin
      thre_pend <= thre_evt | (thre_pend & ~thre_clr);
      ms_pend   <= cts_edge | (ms_pend & ~msr_rd);
    end
  end

  for (genvar k = 0; k < AB_N; k++) begin : g_ab
    logic f_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) f_q <= 1'b0;
      else        f_q <= ab_evt[k] | (f_q & ~(ab_clr & ab_clr_mask[k]));
    end
    assign ab_flags[k] = f_q;
  end

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio #(
  parameter int DATA_W = 32
) (
  input  logic              [DATA_W-1:0] ier,
  input  logic                           lsr_lvl,
  input  logic                           rda_lvl,
  input  logic                           cto_lvl,
  input  logic                           thre_pend,
  input  logic                           ms_pend,
  input  logic                           auto_cts,
  input  logic              [1:0]        ab_flags,
  output uart_irq_pkg::src_t             en_src,
  output logic [uart_irq_pkg::IIR_W-1:0] iir_live,
  output logic                           irq
);
  import uart_irq_pkg::*;

  logic [3:0] low;
  logic       ab_req;

  always_comb begin
    en_src.ls   = lsr_lvl   & ier[B_LS];
    en_src.rda  = rda_lvl   & ier[B_RDA];
    en_src.cto  = cto_lvl   & ier[B_RDA];
    en_src.thre = thre_pend & ier[B_THRE];
    en_src.ms   = ms_pend   & ms_gate(ier[B_MS], ier[B_CTS], auto_cts);
  end

  assign low      = encode_low(en_src);
  assign iir_live = {ab_flags, 4'b0000, low};
  assign ab_req   = (ab_flags[0] & ier[B_ABTO]) | (ab_flags[1] & ier[B_ABEO]);
  assign irq      = ~low[0] | ab_req;

endmodule

// File: rtl/uart_iir_freeze.sv
module uart_iir_freeze #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         iir_rd,
  input  logic [W-1:0] iir_live,
  output logic [W-1:0] iir_q,
  output logic         rd_start,
  output logic         thre_clr
);
  import uart_irq_pkg::*;

  logic rd_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iir_q <= W'(1);
      rd_d  <= 1'b0;
    end else begin
      rd_d <= iir_rd;
      if (!iir_rd) iir_q <= iir_live;
    end
  end

  assign rd_start = iir_rd & ~rd_d;
  assign thre_clr = rd_start & (iir_q[3:0] == {ID_THRE, 1'b0});

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ier_wr,
  input  logic [DATA_W-1:0] ier_wdata,
  output logic [DATA_W-1:0] ier_q,
  input  logic              lsr_lvl,
  input  logic              rda_lvl,
  input  logic              cto_lvl,
  input  logic              thre_evt,
  input  logic              cts_edge,
  input  logic              auto_cts,
  input  logic              msr_rd,
  input  logic              abto_evt,
  input  logic              abeo_evt,
  input  logic              ab_clr,
  input  logic [1:0]        ab_clr_mask,
  input  logic              iir_rd,
  output logic [DATA_W-1:0] iir,
  output logic              irq
);
  import uart_irq_pkg::*;

  localparam int PAD_W = DATA_W - IIR_W;

  // Named internal events (observed by the checker)
  logic             thre_pend;
  logic             ms_pend;
  logic [AB_N-1:0]  ab_flags;
  logic             rd_start;
  logic             thre_clr;
  src_t             en_src;
  logic [IIR_W-1:0] iir_live;
  logic [IIR_W-1:0] iir_hold;

  uart_ier_reg #(.DATA_W(DATA_W)) u_ier (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (ier_wr),
    .wdata (ier_wdata),
    .q     (ier_q)
  );

  uart_irq_sources #(.AB_N(AB_N)) u_src (
    .clk         (clk),
    .rst_n       (rst_n),
    .thre_evt    (thre_evt),
    .thre_clr    (thre_clr),
    .cts_edge    (cts_edge),
    .msr_rd      (msr_rd),
    .ab_evt      ({abeo_evt, abto_evt}),
    .ab_clr      (ab_clr),
    .ab_clr_mask (ab_clr_mask),
    .thre_pend   (thre_pend),
    .ms_pend     (ms_pend),
    .ab_flags    (ab_flags)
  );

  uart_irq_prio #(.DATA_W(DATA_W)) u_prio (
    .ier       (ier_q),
    .lsr_lvl   (lsr_lvl),
    .rda_lvl   (rda_lvl),
    .cto_lvl   (cto_lvl),
    .thre_pend (thre_pend),
    .ms_pend   (ms_pend),
    .auto_cts  (auto_cts),
    .ab_flags  (ab_flags),
    .en_src    (en_src),
    .iir_live  (iir_live),
    .irq       (irq)
  );

  uart_iir_freeze #(.W(IIR_W)) u_frz (
    .clk      (clk),
    .rst_n    (rst_n),
    .iir_rd   (iir_rd),
    .iir_live (iir_live),
    .iir_q    (iir_hold),
    .rd_start (rd_start),
    .thre_clr (thre_clr)
  );

  assign iir = {{PAD_W{1'b0}}, iir_hold};

endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              iir_rd,
  input logic              thre_evt,
  input logic              abto_evt,
  input logic              auto_cts,
  input logic [DATA_W-1:0] ier_q,
  input logic [DATA_W-1:0] iir,
  input logic [9:0]        iir_live,
  input logic              irq,
  input logic              rd_start,
  input logic              thre_pend,
  input logic [1:0]        ab_flags
);

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_q[6:4] == 3'b000) && (ier_q[DATA_W-1:10] == '0));

  a_r3_legal_identity: assert property (@(posedge clk) disable iff (!rst_n)
    !iir[0] |-> (iir[3:1] == 3'b011 || iir[3:1] == 3'b010 || iir[3:1] == 3'b110 ||
                 iir[3:1] == 3'b001 || iir[3:1] == 3'b000));

  a_r4_idle_identity: assert property (@(posedge clk) disable iff (!rst_n)
    iir[0] |-> (iir[3:1] == 3'b000));

  a_r5_autocts_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_cts && !ier_q[7]) |-> (iir_live[3:0] != 4'b0000));

  a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    iir_rd |=> $stable(iir));

  a_r8_thre_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start && iir[3:0] == 4'b0010 && !thre_evt) |=> !thre_pend);

  a_r9_abto_latch: assert property (@(posedge clk) disable iff (!rst_n)
    abto_evt |=> ab_flags[0]);

  a_r10_ab_request: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_flags[0] && ier_q[8]) |-> irq);

endmodule

bind uart_irq_ident uart_irq_ident_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .iir_rd    (iir_rd),
  .thre_evt  (thre_evt),
  .abto_evt  (abto_evt),
  .auto_cts  (auto_cts),
  .ier_q     (ier_q),
  .iir       (iir),
  .iir_live  (iir_live),
  .irq       (irq),
  .rd_start  (rd_start),
  .thre_pend (thre_pend),
  .ab_flags  (ab_flags)
);

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb;
  localparam int DATA_W = 32;
  localparam int CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ier_wr = 1'b0;
  logic [DATA_W-1:0] ier_wdata = '0;
  logic [DATA_W-1:0] ier_q;
  logic lsr_lvl = 0, rda_lvl = 0, cto_lvl = 0, thre_evt = 0, cts_edge = 0;
  logic auto_cts = 0, msr_rd = 0, abto_evt = 0, abeo_evt = 0, ab_clr = 0;
  logic [1:0]        ab_clr_mask = '0;
  logic              iir_rd = 1'b0;
  logic [DATA_W-1:0] iir;
  logic              irq;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_ident #(.DATA_W(DATA_W)) u_dut (.*);

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_ier(logic [DATA_W-1:0] v);
    ier_wdata = v; ier_wr = 1'b1; step(); ier_wr = 1'b0; step();
  endtask

  task automatic read_iir(int cycles);
    iir_rd = 1'b1; step(cycles); iir_rd = 1'b0; step(2);
  endtask

  task automatic clear_all();
    lsr_lvl = 0; rda_lvl = 0; cto_lvl = 0; auto_cts = 0;
    msr_rd = 1; ab_clr = 1; ab_clr_mask = 2'b11; step();
    msr_rd = 0; ab_clr = 0; ab_clr_mask = 2'b00;
    wr_ier(32'h2); read_iir(1); wr_ier(32'h0); step(2);
  endtask

  task automatic t_reset();
    check("R1 ier", ier_q, 32'h0);
    check("R1 iir", iir, 32'h1);
    check("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_ier();
    wr_ier('1);
    check("R2 implemented bits", ier_q, 32'h38F);
    wr_ier(32'h0);
    check("R2 cleared", ier_q, 32'h0);
  endtask

  task automatic t_gating();
    lsr_lvl = 1; rda_lvl = 1; step(2);
    check("R11 disabled iir", iir, 32'h1);
    check("R11 disabled irq", {31'b0, irq}, 32'h0);
    wr_ier(32'h4); step();
    check("R11 line status enabled", iir, 32'h6);
    lsr_lvl = 0; rda_lvl = 0; wr_ier(32'h0); step();
  endtask

  task automatic t_prio();
    wr_ier(32'h0F);
    lsr_lvl = 1; rda_lvl = 1; cto_lvl = 1; thre_evt = 1; cts_edge = 1; step();
    thre_evt = 0; cts_edge = 0; step(2);
    check("R3 line status top", iir, 32'h6);
    check("R4 irq pending", {31'b0, irq}, 32'h1);
    lsr_lvl = 0; step(2);
    check("R3 receive data", iir, 32'h4);
    rda_lvl = 0; step(2);
    check("R3 char timeout", iir, 32'hC);
    cto_lvl = 0; step(2);
    check("R3 thre", iir, 32'h2);
    read_iir(1);
    check("R8 thre cleared, modem status", iir, 32'h0);
    msr_rd = 1; step(); msr_rd = 0; step(2);
    check("R8 modem cleared, R4 idle", iir, 32'h1);
    check("R4 irq idle", {31'b0, irq}, 32'h0);
    wr_ier(32'h0);
  endtask

  task automatic t_cts();
    wr_ier(32'h08);
    cts_edge = 1; step(); cts_edge = 0; step(2);
    check("R5 normal mode cts", iir, 32'h0);
    msr_rd = 1; step(); msr_rd = 0;
    auto_cts = 1;
    cts_edge = 1; step(); cts_edge = 0; step(2);
    check("R5 auto mode without bit7", iir, 32'h1);
    check("R5 auto mode irq low", {31'b0, irq}, 32'h0);
    wr_ier(32'h88); step();
    check("R5 auto mode with bit7", iir, 32'h0);
    msr_rd = 1; step(); msr_rd = 0; auto_cts = 0;
    wr_ier(32'h0); step();
  endtask

  task automatic t_freeze();
    wr_ier(32'h0F); step();
    check("R6 idle before read", iir, 32'h1);
    iir_rd = 1'b1; step();
    thre_evt = 1; lsr_lvl = 1; step(); thre_evt = 0;
    step();
    check("R6 frozen during read", iir, 32'h1);
    step(2);
    check("R6 still frozen", iir, 32'h1);
    iir_rd = 1'b0; step(2);
    check("R7 deferred line status", iir, 32'h6);
    lsr_lvl = 0; step(2);
    check("R7 deferred thre kept", iir, 32'h2);
    read_iir(1);
    check("R8 read clears thre", iir, 32'h1);
    wr_ier(32'h0);
  endtask

  task automatic t_autobaud();
    abto_evt = 1; step(); abto_evt = 0; step(2);
    check("R9 abto flag", iir, 32'h101);
    check("R10 flag not enabled", {31'b0, irq}, 32'h0);
    wr_ier(32'h100);
    check("R10 enabled flag irq", {31'b0, irq}, 32'h1);
    abeo_evt = 1; step(); abeo_evt = 0; step(2);
    check("R9 abeo flag", iir, 32'h301);
    ab_clr = 1; ab_clr_mask = 2'b01; step(); ab_clr = 0; step(2);
    check("R9 clear bit8", iir, 32'h201);
    check("R10 bit9 not enabled", {31'b0, irq}, 32'h0);
    ab_clr = 1; ab_clr_mask = 2'b10; abeo_evt = 1; step();
    ab_clr = 0; abeo_evt = 0; step(2);
    check("R9 set wins", iir, 32'h201);
    ab_clr = 1; step(); ab_clr = 0; ab_clr_mask = 2'b00; step(2);
    check("R9 clear bit9", iir, 32'h001);
    wr_ier(32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    step(3);
    t_reset();
    rst_n = 1'b1; step(2);
    t_reset();
    t_ier();
    t_gating();
    clear_all();
    t_prio();
    clear_all();
    t_cts();
    clear_all();
    t_freeze();
    clear_all();
    t_autobaud();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule